// File: doc/BRIEF.md
# Chip-Select Pulse Clock Calibrator

This block sets the period of an on-chip clock from a timing reference held by the host controller. A decoder elsewhere sends a one-cycle arm strobe when the host writes the calibration command. After that strobe the block waits for the chip-select line to go low. It then counts, in cycles of a fast reference clock, how long the line stays low. The low time stands for 128 periods of the internal clock, so the count is divided by 128 (with rounding) to give the new period value.

A pulse whose length falls outside an accepted window is thrown away. In that case the block keeps the last good period, or the default period if no calibration has succeeded yet. Each arm strobe allows exactly one measured pulse, whether that pulse is accepted or not.

The control state machine has four states:
- `ST_IDLE` moves to `ST_ARMED` on the arm strobe.
- `ST_ARMED` moves to `ST_MEASURE` on a synchronised falling edge of chip-select.
- `ST_MEASURE` returns to `ST_IDLE` on the rising edge. The pulse is judged at that point.
- `ST_MEASURE` moves to `ST_OVERRUN` if the count reaches its ceiling while chip-select is still low.
- `ST_OVERRUN` returns to `ST_IDLE` on the rising edge, with the pulse rejected.

Top module: `csc_calibrator`

## Requirements
- R1: While reset is asserted, and right after it is released, `period_o` equals DEF_PERIOD (16) and `calibrated_o` is 0. A reset during a measurement drops that measurement.
- R2: A chip-select low pulse that is not preceded by an arm strobe leaves `period_o` and `calibrated_o` unchanged. An arm strobe that arrives outside `ST_IDLE` is ignored.
- R3: A low pulse of L reference cycles with MIN_CNT (1843) ≤ L ≤ MAX_CNT (2252) sets `period_o` to floor((L+64)/128) and sets `calibrated_o` to 1. The flag then stays 1 until reset.
- R4: A low pulse with L < MIN_CNT is rejected: `period_o` and `calibrated_o` keep their previous values.
- R5: The measurement counter stops at MAX_CNT. A pulse with L > MAX_CNT is rejected, and `period_o` and `calibrated_o` keep their values.
- R6: The armed condition ends after one measured pulse, whether it was accepted or rejected. A second pulse needs a new arm strobe.
- R7: Chip-select passes through a two-stage synchroniser. An accepted result appears on `period_o` at the third rising clock edge after `cs_n_i` returns high, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_arm_i | input | 1 | One-cycle strobe from the command decoder |
| cs_n_i | input | 1 | Chip-select line, active low, asynchronous |
| period_o | output | CNT_W-6 | Internal clock period, in reference cycles |
| calibrated_o | output | 1 | High once any calibration has been accepted |

## Verification
Every result of this block appears on the third rising edge after chip-select is released. Two of those edges come from the synchroniser and one from the result register. The table-driven checks wait six edges after the release and sample at a falling edge, so each check sees the settled value for the pulse just sent. One directed test looks at the outputs after two edges, where the old period must still be present, and again after three edges, where the new period must be present. This pins the latency of R7 exactly. Rejected and unarmed pulses are checked with the same delay, so that a wrongful update would already be visible when the check runs.

// File: rtl/csc_pkg.sv
package csc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_MEASURE = 2'd2,
        ST_OVERRUN = 2'd3
    } cal_state_t;
endpackage

// File: rtl/csc_cs_sync.sv
module csc_cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    output logic cs_level_o,
    output logic fall_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= cs_n_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b1;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= chain_q[STAGES-1];
    end

    assign cs_level_o = chain_q[STAGES-1];
    assign fall_o     = last_q & ~chain_q[STAGES-1];
    assign rise_o     = ~last_q & chain_q[STAGES-1];
endmodule

// File: rtl/csc_pulse_counter.sv
module csc_pulse_counter #(
    parameter int CNT_W   = 12,
    parameter int MAX_CNT = 2252
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             at_max_o
);
    localparam logic [CNT_W-1:0] CEIL = CNT_W'(MAX_CNT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (load_i)                 cnt_q <= CNT_W'(1);
        else if (inc_i && cnt_q != CEIL) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o    = cnt_q;
    assign at_max_o = (cnt_q == CEIL);
endmodule

// File: rtl/csc_calibrator.sv
module csc_calibrator #(
    parameter int CNT_W      = 12,
    parameter int SCALE_LOG2 = 7,
    parameter int MIN_CNT    = 1843,
    parameter int MAX_CNT    = 2252,
    parameter int DEF_PERIOD = 16,
    parameter int SYNC_DEPTH = 2,
    localparam int PER_W     = CNT_W + 1 - SCALE_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_arm_i,
    input  logic             cs_n_i,
    output logic [PER_W-1:0] period_o,
    output logic             calibrated_o
);
    import csc_pkg::*;

    localparam logic [CNT_W:0] HALF_LSB = (CNT_W+1)'(1) << (SCALE_LOG2 - 1);
    localparam logic [CNT_W-1:0] LO_LIM = CNT_W'(MIN_CNT);
    localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(MAX_CNT);

    cal_state_t       state_q, state_d;
    logic             cs_level, cs_fall, cs_rise;
    logic [CNT_W-1:0] cnt;
    logic             at_max;
    logic             cnt_load, cnt_inc;
    logic             in_window, accept;
    logic [CNT_W:0]   rounded;
    logic [PER_W-1:0] period_q;
    logic             cal_q;

    csc_cs_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n_i),
        .cs_level_o (cs_level),
        .fall_o     (cs_fall),
        .rise_o     (cs_rise)
    );

    csc_pulse_counter #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (cnt_load),
        .inc_i    (cnt_inc),
        .cnt_o    (cnt),
        .at_max_o (at_max)
    );

    assign cnt_load  = (state_q == ST_ARMED) && cs_fall;
    assign cnt_inc   = (state_q == ST_MEASURE) && !cs_rise;
    assign in_window = (cnt >= LO_LIM) && (cnt <= HI_LIM);
    assign accept    = (state_q == ST_MEASURE) && cs_rise && in_window;
    assign rounded   = {1'b0, cnt} + HALF_LSB;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cal_arm_i)          state_d = ST_ARMED;
            ST_ARMED:   if (cs_fall)            state_d = ST_MEASURE;
            ST_MEASURE: if (cs_rise)            state_d = ST_IDLE;
                        else if (at_max)        state_d = ST_OVERRUN;
            ST_OVERRUN: if (cs_rise || cs_level) state_d = ST_IDLE;
            default:                            state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= PER_W'(DEF_PERIOD);
            cal_q    <= 1'b0;
        end else if (accept) begin
            period_q <= rounded[CNT_W:SCALE_LOG2];
            cal_q    <= 1'b1;
        end
    end

    assign period_o     = period_q;
    assign calibrated_o = cal_q;
endmodule

// File: rtl/csc_calibrator_chk.sv
module csc_calibrator_chk #(
    parameter int CNT_W   = 12,
    parameter int MIN_CNT = 1843,
    parameter int MAX_CNT = 2252,
    parameter int PER_W   = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                arm_i,
    input csc_pkg::cal_state_t state_i,
    input logic                rise_i,
    input logic [CNT_W-1:0]    cnt_i,
    input logic [PER_W-1:0]    period_i,
    input logic                cal_i
);
    import csc_pkg::*;

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_IDLE && !arm_i) |=> (state_i == ST_IDLE));

    assert_period_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != ST_MEASURE) |=> $stable(period_i));

    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cal_i |=> cal_i);

    assert_accept_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_MEASURE && rise_i && cnt_i >= CNT_W'(MIN_CNT)) |=> cal_i);

    assert_short_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_MEASURE && rise_i && cnt_i < CNT_W'(MIN_CNT)) |=> $stable(period_i));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_i <= CNT_W'(MAX_CNT));

    assert_overrun_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_OVERRUN) |=> $stable(period_i));

    assert_single_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_MEASURE && rise_i) |=> (state_i == ST_IDLE));
endmodule

bind csc_calibrator csc_calibrator_chk #(
    .CNT_W   (CNT_W),
    .MIN_CNT (MIN_CNT),
    .MAX_CNT (MAX_CNT),
    .PER_W   (PER_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (cal_arm_i),
    .state_i  (state_q),
    .rise_i   (cs_rise),
    .cnt_i    (cnt),
    .period_i (period_o),
    .cal_i    (calibrated_o)
);

// File: tb/test_csc_calibrator.sv
module test_csc_calibrator;
    localparam int CLK_PERIOD = 10;
    localparam int PER_W      = 6;
    localparam int NVEC       = 8;

    localparam bit VEC_ARM [NVEC] = '{1, 1, 0, 1, 1, 1, 0, 1};
    localparam int VEC_LEN [NVEC] = '{2048, 1842, 1843, 1843, 2253, 2252, 2048, 2111};
    localparam int VEC_PER [NVEC] = '{16, 16, 16, 14, 14, 18, 18, 16};
    localparam string VEC_REQ [NVEC] = '{"R3", "R4", "R6", "R3", "R5", "R3", "R2", "R3"};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cal_arm_i = 1'b0;
    logic             cs_n_i = 1'b1;
    logic [PER_W-1:0] period_o;
    logic             calibrated_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csc_calibrator i_csc_calibrator (
        .clk          (clk),
        .rst_n        (rst_n),
        .cal_arm_i    (cal_arm_i),
        .cs_n_i       (cs_n_i),
        .period_o     (period_o),
        .calibrated_o (calibrated_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic arm();
        @(negedge clk) cal_arm_i = 1'b1;
        @(negedge clk) cal_arm_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse(input int len);
        @(negedge clk) cs_n_i = 1'b0;
        repeat (len) @(negedge clk);
        cs_n_i = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset values, during and right after reset
        repeat (3) @(negedge clk);
        chk("R1", "period in reset", int'(period_o), 16);
        chk("R1", "flag in reset", int'(calibrated_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "period after reset", int'(period_o), 16);
        chk("R1", "flag after reset", int'(calibrated_o), 0);

        // R4: rejection before any success keeps the default
        arm();
        pulse(1000);
        repeat (6) @(negedge clk);
        chk("R4", "period default kept", int'(period_o), 16);
        chk("R4", "flag still low", int'(calibrated_o), 0);

        // table-driven main function
        for (int v = 0; v < NVEC; v++) begin
            if (VEC_ARM[v]) arm();
            pulse(VEC_LEN[v]);
            repeat (6) @(negedge clk);
            chk(VEC_REQ[v], $sformatf("vector %0d period", v), int'(period_o), VEC_PER[v]);
            chk(VEC_REQ[v], $sformatf("vector %0d flag", v), int'(calibrated_o), 1);
        end

        // R7: latency of an accepted result, 2176 -> 17
        arm();
        pulse(2176);
        repeat (2) @(negedge clk);
        chk("R7", "period after two edges", int'(period_o), 16);
        @(negedge clk);
        chk("R7", "period after three edges", int'(period_o), 17);

        // R2: arm during measurement ignored, single pulse then idle
        arm();
        @(negedge clk) cs_n_i = 1'b0;
        repeat (50) @(negedge clk);
        cal_arm_i = 1'b1;
        @(negedge clk) cal_arm_i = 1'b0;
        repeat (1998) @(negedge clk);
        cs_n_i = 1'b1;
        repeat (6) @(negedge clk);
        chk("R3", "pulse with stray arm", int'(period_o), 16);
        pulse(2252);
        repeat (6) @(negedge clk);
        chk("R2", "stray arm did not re-arm", int'(period_o), 16);

        // R1: reset in the middle of a measurement
        arm();
        @(negedge clk) cs_n_i = 1'b0;
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "period after mid reset", int'(period_o), 16);
        chk("R1", "flag after mid reset", int'(calibrated_o), 0);
        rst_n = 1'b1;
        repeat (1900) @(negedge clk);
        cs_n_i = 1'b1;
        repeat (6) @(negedge clk);
        chk("R1", "dropped measurement flag", int'(calibrated_o), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule